// File: doc/BRIEF.md
# Hardware Interrupt Level Steering Unit

The unit collects 32 level-sensitive hardware interrupt lines. It converts them to processor priority levels through a fixed table and presents the result to exactly one programmable processor. Each line passes through a fixed mapping to a level from 1 to 15, or to 0 when the line is unused. Unused lines are dropped at the input. A 32-bit disable word filters which lines may reach the processor. Only the lines in a fixed maskable set can ever be enabled; the remaining lines stay disabled permanently. The top bit of the disable word mutes all hardware levels at once.

Software reaches the unit through a small word-addressed register window. Through it, software reads the latched lines and the disable word, clears or sets disable bits with separate strobe offsets, and picks the target processor. The selected processor receives a 16-bit level vector of the enabled, pending lines. Every processor also receives a mirror vector. The mirror holds the unmasked mapped levels for the target processor only. Bit 15 of the mirror is set in every processor's mirror whenever a level-15 line is high.

Top module: `irq_steer`

## Requirements
- R1: After reset the pending word is 0, the target is 0, the disable word is 0x0FA2007F (offset 1 therefore reads 0), and every level and mirror output is zero.
- R2: Lines whose table level is 0 (lines 23 to 26 and 31) never set a pending bit. With all inputs high, offset 0 reads 0x787FFFFF.
- R3: Every mapped line i is sampled each clock into pending bit i. Offset 0 returns the pending word with bit 31 forced to 0.
- R4: A write to word offset 2 clears the disable bits set in (data AND 0xF05DFF80). A write to word offset 3 sets the disable bits set in (data AND 0xF05DFF80). Bits outside 0xF05DFF80 keep their reset value.
- R5: Offset 1 reads the disable word AND 0xF05DFF80. Offsets 2, 3, 5, 6 and 7 read 0.
- R6: A write to word offset 4 stores data bits 3:0 as the target number, and offset 4 reads it back zero-extended.
- R7: The target's level vector has bit L set when some line with table level L is pending and not disabled. The table for lines 0..31 is 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0. The vector is all zero while disable bit 31 is set.
- R8: Every processor other than the target, including every processor when the target number is at or above the processor count, gets an all-zero level vector.
- R9: The target's mirror vector holds the mapped levels of all pending lines, disable word ignored. Every processor's mirror has bit 15 set while any of lines 27 to 30 is pending.
- R10: Outputs are registered. A line change shows on the level and mirror outputs two clocks later. A register write shows one clock later, and read data reflects the address presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32 | Level-sensitive hardware interrupt lines |
| reg_addr | input | 3 | Word offset into the register window |
| reg_wr | input | 1 | Write strobe for reg_addr |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's reg_addr |
| cpu_level | output | NCPU*16 | Per-processor level vectors, processor c at bits c*16+15:c*16 |
| cpu_mirror | output | NCPU*16 | Per-processor mirror vectors, same packing |

## Verification
Random line patterns of mixed density go to a bench model, together with random writes to all eight offsets. The model separates the disabled-but-pending path, which feeds only the mirror, from the enabled path that feeds the level vector. Directed cases drive all lines high to expose the unused lines and the permanently disabled ones. They enable and then disable everything to tell the maskable set from the fixed bits. They set the master-disable bit to show the level vector muted while the mirror stays live. They also program a target beyond the processor count, leaving only the level-15 broadcast.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int NSRC  = 32;
  localparam int LVL_N = 16;
  localparam int LVL_W = 4;
  localparam int OFS_W = 3;

  localparam logic [NSRC-1:0] MASKABLE  = 32'hF05DFF80;
  localparam logic [NSRC-1:0] DIS_RESET = ~MASKABLE;
  localparam int              MUTE_BIT  = NSRC - 1;

  typedef enum logic [OFS_W-1:0] {
    OFS_PEND   = 3'd0,
    OFS_DIS    = 3'd1,
    OFS_EN     = 3'd2,
    OFS_DISSET = 3'd3,
    OFS_TGT    = 3'd4
  } reg_ofs_e;

  function automatic logic [LVL_W-1:0] src_level(input int unsigned i);
    case (i)
      0, 7:                 src_level = 4'd2;
      1, 8:                 src_level = 4'd3;
      2, 9:                 src_level = 4'd5;
      3, 10:                src_level = 4'd7;
      4, 11, 21:            src_level = 4'd9;
      5, 12, 22:            src_level = 4'd11;
      6, 13, 17:            src_level = 4'd13;
      14, 15:               src_level = 4'd12;
      16:                   src_level = 4'd6;
      18:                   src_level = 4'd4;
      19:                   src_level = 4'd10;
      20:                   src_level = 4'd8;
      27, 28, 29, 30:       src_level = 4'd15;
      default:              src_level = 4'd0;
    endcase
  endfunction

  function automatic logic [NSRC-1:0] mapped_sources();
    logic [NSRC-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[i] = (src_level(i) != '0);
    return m;
  endfunction

  function automatic logic [LVL_N-1:0] levels_of(input logic [NSRC-1:0] bits);
    logic [LVL_N-1:0] v;
    v = '0;
    for (int i = 0; i < NSRC; i++)
      if (bits[i] && src_level(i) != '0) v[src_level(i)] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
  import irq_steer_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] lines,
  output logic [NSRC-1:0] pend
);
  localparam logic [NSRC-1:0] VALID = mapped_sources();

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= lines & VALID;
  end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_steer_pkg::*;
#(
  parameter int TGT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFS_W-1:0] addr,
  input  logic             wr,
  input  logic [NSRC-1:0]  wdata,
  input  logic [NSRC-1:0]  pend,
  output logic [NSRC-1:0]  dis,
  output logic [TGT_W-1:0] tgt,
  output logic [NSRC-1:0]  rdata
);
  logic [NSRC-1:0] wmask;
  logic [NSRC-1:0] rd_next;

  assign wmask = wdata & MASKABLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      dis <= DIS_RESET;
      tgt <= '0;
    end else if (wr) begin
      case (addr)
        OFS_EN:     dis <= dis & ~wmask;
        OFS_DISSET: dis <= dis | wmask;
        OFS_TGT:    tgt <= wdata[TGT_W-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_PEND: rd_next = pend & ~(NSRC'(1) << MUTE_BIT);
      OFS_DIS:  rd_next = dis & MASKABLE;
      OFS_TGT:  rd_next = NSRC'(tgt);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_steer_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int TGT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       pend,
  input  logic [NSRC-1:0]       dis,
  input  logic [TGT_W-1:0]      tgt,
  output logic [NCPU*LVL_N-1:0] level_o,
  output logic [NCPU*LVL_N-1:0] mirror_o
);
  logic [NSRC-1:0]  eff;
  logic [LVL_N-1:0] gated;
  logic [LVL_N-1:0] raw;
  logic [LVL_N-1:0] bcast;

  assign eff   = pend & ~dis;
  assign gated = (eff != '0 && !dis[MUTE_BIT]) ? levels_of(eff) : '0;
  assign raw   = levels_of(pend);
  assign bcast = {raw[LVL_N-1], {(LVL_N-1){1'b0}}};

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic hit;
    assign hit = (tgt == TGT_W'(c));
    always_ff @(posedge clk) begin
      if (rst) begin
        level_o[c*LVL_N +: LVL_N]  <= '0;
        mirror_o[c*LVL_N +: LVL_N] <= '0;
      end else begin
        level_o[c*LVL_N +: LVL_N]  <= hit ? gated : '0;
        mirror_o[c*LVL_N +: LVL_N] <= (hit ? raw : '0) | bcast;
      end
    end
  end
endmodule

// File: rtl/irq_steer.sv
module irq_steer
  import irq_steer_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int TGT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [31:0]            irq_lines,
  input  logic [2:0]             reg_addr,
  input  logic                   reg_wr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic [NCPU*16-1:0]     cpu_level,
  output logic [NCPU*16-1:0]     cpu_mirror
);
  logic [NSRC-1:0]  pend_q;
  logic [NSRC-1:0]  dis_q;
  logic [TGT_W-1:0] tgt_q;

  irq_src_latch u_latch (
    .clk(clk), .rst(rst), .lines(irq_lines), .pend(pend_q)
  );

  irq_mask_regs #(.TGT_W(TGT_W)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .pend(pend_q), .dis(dis_q), .tgt(tgt_q), .rdata(reg_rdata)
  );

  irq_route #(.NCPU(NCPU), .TGT_W(TGT_W)) u_route (
    .clk(clk), .rst(rst), .pend(pend_q), .dis(dis_q), .tgt(tgt_q),
    .level_o(cpu_level), .mirror_o(cpu_mirror)
  );
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
  import irq_steer_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int TGT_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NSRC-1:0]       pend,
  input logic [NSRC-1:0]       dis,
  input logic [TGT_W-1:0]      tgt,
  input logic [OFS_W-1:0]      addr,
  input logic [NSRC-1:0]       rdata,
  input logic [NCPU*LVL_N-1:0] level,
  input logic [NCPU*LVL_N-1:0] mirror
);
  localparam logic [NSRC-1:0] VALID = mapped_sources();

  a_r2_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
    (pend & ~VALID) == '0);

  a_r4_fixed_bits_held: assert property (@(posedge clk) disable iff (rst)
    (dis & ~MASKABLE) == ~MASKABLE);

  a_r7_master_mute: assert property (@(posedge clk) disable iff (rst)
    $past(dis[MUTE_BIT]) |-> level == '0);

  a_r5_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) > 3'd4) |-> rdata == '0);

  a_r3_top_bit_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == 3'd0) |-> !rdata[NSRC-1]);

  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    a_r8_offtarget_zero: assert property (@(posedge clk) disable iff (rst)
      ($past(tgt) != TGT_W'(c)) |-> level[c*LVL_N +: LVL_N] == '0);
    a_r9_broadcast15: assert property (@(posedge clk) disable iff (rst)
      $past(|pend[30:27]) |-> mirror[c*LVL_N + LVL_N - 1]);
  end
endmodule

bind irq_steer irq_steer_chk #(.NCPU(NCPU), .TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst(rst), .pend(pend_q), .dis(dis_q), .tgt(tgt_q),
  .addr(reg_addr), .rdata(reg_rdata), .level(cpu_level), .mirror(cpu_mirror)
);

// File: tb/irq_steer_bench.sv
module irq_steer_bench;
  localparam int NCPU = 4;
  localparam logic [31:0] MSK = 32'hF05DFF80;
  localparam int LV [32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                             6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] irq_lines = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCPU*16-1:0] cpu_level, cpu_mirror;

  irq_steer #(.NCPU(NCPU), .TGT_W(4)) u_irq_steer (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_level(cpu_level), .cpu_mirror(cpu_mirror)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_pend, m_dis, m_rd;
  logic [3:0]  m_tgt;
  logic [NCPU*16-1:0] m_lvl, m_mir;

  function automatic logic [15:0] lv_of(input logic [31:0] b);
    logic [15:0] v = '0;
    for (int i = 0; i < 32; i++) if (b[i] && LV[i] != 0) v[LV[i]] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] valid_bits();
    logic [31:0] v = '0;
    for (int i = 0; i < 32; i++) v[i] = (LV[i] != 0);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pend <= '0; m_dis <= 32'h0FA2007F; m_tgt <= '0; m_rd <= '0;
      m_lvl <= '0; m_mir <= '0;
    end else begin
      logic [31:0] eff;
      logic [15:0] raw;
      eff = m_pend & ~m_dis;
      raw = lv_of(m_pend);
      for (int c = 0; c < NCPU; c++) begin
        m_lvl[c*16 +: 16] <= (c == m_tgt && eff != 0 && !m_dis[31]) ? lv_of(eff) : 16'h0;
        m_mir[c*16 +: 16] <= ((c == m_tgt) ? raw : 16'h0) | {raw[15], 15'h0};
      end
      case (reg_addr)
        3'd0: m_rd <= m_pend & 32'h7FFFFFFF;
        3'd1: m_rd <= m_dis & MSK;
        3'd4: m_rd <= {28'h0, m_tgt};
        default: m_rd <= '0;
      endcase
      m_pend <= irq_lines & valid_bits();
      if (reg_wr) begin
        if (reg_addr == 3'd2) m_dis <= m_dis & ~(reg_wdata & MSK);
        if (reg_addr == 3'd3) m_dis <= m_dis | (reg_wdata & MSK);
        if (reg_addr == 3'd4) m_tgt <= reg_wdata[3:0];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(reg_rdata == m_rd, "R3/R5/R6 read data", {32'h0, reg_rdata}, {32'h0, m_rd});
    chk(cpu_level == m_lvl, "R7/R8 level vectors", cpu_level, m_lvl);
    chk(cpu_mirror == m_mir, "R9 mirror vectors", cpu_mirror, m_mir);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [31:0] e, input string req);
    reg_addr = a; reg_wr = 1'b0;
    tick();
    chk(reg_rdata == e, req, {32'h0, reg_rdata}, {32'h0, e});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234ABCD));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(cpu_level == '0 && cpu_mirror == '0, "R1 outputs after reset", cpu_level, 64'h0);
    rd_expect(3'd1, 32'h0, "R1 disable readback after reset");
    rd_expect(3'd4, 32'h0, "R1 target after reset");
    rd_expect(3'd0, 32'h0, "R1 pending after reset");

    // R2: all lines high, unused lines stay clear
    irq_lines = 32'hFFFFFFFF;
    tick();
    rd_expect(3'd0, 32'h787FFFFF, "R2 unmapped lines never pend");
    // R9: disabled-only lines still show in mirror; bit15 broadcast
    chk(cpu_mirror[NCPU*16-1] == 1'b1, "R9 broadcast level 15", {63'h0, cpu_mirror[NCPU*16-1]}, 64'h1);

    // R4: enable everything, then disable everything
    wr(3'd2, 32'hFFFFFFFF);
    rd_expect(3'd1, 32'h0, "R4 enable clears maskable set");
    tick();
    chk(cpu_level[15] == 1'b1 && cpu_level[2] == 1'b1, "R7 target sees levels 15 and 2", {48'h0, cpu_level[15:0]}, 64'h0);
    wr(3'd3, 32'hFFFFFFFF);
    rd_expect(3'd1, 32'hF05DFF80, "R4 disable sets maskable set");
    chk(cpu_level == '0, "R7 master mute", cpu_level, 64'h0);

    // R6: target wider than 4 bits, then out of range
    wr(3'd2, 32'hFFFFFFFF);
    wr(3'd4, 32'h0000001F);
    rd_expect(3'd4, 32'h0000000F, "R6 target keeps low bits");
    tick();
    chk(cpu_level == '0, "R8 out-of-range target gets nothing", cpu_level, 64'h0);
    wr(3'd4, 32'h2);
    tick();
    chk(cpu_level[15:0] == 16'h0 && cpu_level[47:32] != 16'h0, "R8 only cpu 2 driven", cpu_level, 64'h0);
    rd_expect(3'd6, 32'h0, "R5 hole offset reads zero");
    rd_expect(3'd2, 32'h0, "R5 strobe offset reads zero");

    // R10 latency: line change appears two clocks later
    irq_lines = 32'h0;
    tick();
    chk(cpu_level[47:32] != 16'h0, "R10 one clock: level still old", {48'h0, cpu_level[47:32]}, 64'h1);
    tick();
    chk(cpu_level == '0 && cpu_mirror == '0, "R10 two clocks: level cleared", cpu_level, 64'h0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = $urandom % 4;
      case (r)
        0: irq_lines = $urandom;
        1: irq_lines = $urandom & $urandom & $urandom;
        2: irq_lines = 32'h1 << ($urandom % 32);
        default: ;
      endcase
      reg_addr  = 3'($urandom % 8);
      reg_wdata = $urandom;
      if (reg_addr == 3'd4 && ($urandom % 4) != 0) reg_wdata = $urandom % NCPU;
      reg_wr    = (($urandom % 4) == 0);
      tick();
    end
    reg_wr = 1'b0;
    tick();
    finish_run();
  end
endmodule